// File: doc/BRIEF.md
# Multi-Mode Two-Dimensional Strided Copy Engine

This engine moves a rectangular block of bytes from one region of a byte-wide, word-addressed memory to another region of the same memory. It can reshape the block while it moves it. In plain copy the layout is kept. In transpose the rows and columns are swapped. In fuse, two matrices with the same number of rows are placed side by side in one wider matrix. The read side and the write side each have their own start address and their own row gap. The row gap is the number of unused bytes between the end of one row and the start of the next.

A session starts with a single-cycle start pulse. At that pulse the engine latches its whole context: function code, addresses, gaps and sizes. It then walks the elements one at a time through a single-port memory port that has a request/ready handshake. Each element is read once and written once. When the last write is accepted, the engine raises a one-cycle done pulse. A controller can change the context inputs as soon as start has been sampled.

Top module: `dma2d_engine`

## Requirements
- R1: With function code 0 (copy), the element at source row r, column c is written to destination row r, column c. There are `rows_i` rows and `cols_i` columns, and the destination row length is `cols_i`.
- R2: With function code 1 (transpose), the element at source row r, column c is written to destination row c, column r. The destination has `cols_i` rows of length `rows_i`.
- R3: With function code 2 (fuse), the engine runs two passes. The first pass copies an `rows_i`×`cols_i` matrix from `src_addr_i`. The second pass copies an `rows_i`×`cols2_i` matrix from `src2_addr_i` and places it at destination column offset `cols_i`. The destination row length is `cols_i+cols2_i`. The second pass is skipped when `cols2_i` is 0.
- R4: The source address of an element is base + row×(row length + `src_gap_i`) + column. The destination address is `dst_addr_i` + row×(destination row length + `dst_gap_i`) + column. The bytes in the destination gaps are never written.
- R5: Each element takes exactly one read followed by exactly one write, and the write carries the byte that was read. A read is always followed by a write.
- R6: While a request is not yet accepted (`mem_rdy_i` low), the request, write enable and address stay unchanged. Only one access is ever pending.
- R7: A start with function code 3 is ignored. The engine stays idle, performs no access and gives no done pulse.
- R8: If the row count or the column count is 0, the engine raises done in the cycle after start and performs no access.
- R9: All context inputs are sampled on the start cycle. Changes to them during the session have no effect on the transfer.
- R10: A start pulse while busy is ignored. No second session follows.
- R11: Done is a single-cycle pulse in the cycle after the last write is accepted. `busy_o` is high from the cycle after start through the done cycle.
- R12: After reset the engine is idle, with no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| func_i | input | 2 | Function: 0 copy, 1 transpose, 2 fuse, 3 invalid |
| src_addr_i | input | AW | Start address of the source (first matrix in fuse) |
| src2_addr_i | input | AW | Start address of the second fuse matrix |
| src_gap_i | input | AW | Gap between source rows |
| dst_addr_i | input | AW | Start address of the destination |
| dst_gap_i | input | AW | Gap between destination rows |
| rows_i | input | CW | Row count of the source |
| cols_i | input | CW | Column count of the source (first matrix in fuse) |
| cols2_i | input | CW | Column count of the second fuse matrix |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid while `mem_rdy_i` is high |
| mem_rdy_i | input | 1 | Access accepted in this cycle |

## Verification
The bench checks transposes of non-square shapes and of a 1×1 block. A design that mixed up the row and column lengths would write into the destination gaps, and the bench finds those gap bytes changed. It runs fuse with and without a second matrix; a wrong column offset would overwrite the first matrix, and a second pass that is not skipped would show up as extra writes. It also tests zero-sized blocks, an invalid function code, a second start and context changes in mid-session. An engine that re-read its inputs or restarted would write to the changed addresses or raise done twice. Runs with a randomly stalling ready signal show whether an address moved while its request was still waiting.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    FN_COPY  = 2'd0,
    FN_XPOSE = 2'd1,
    FN_FUSE  = 2'd2,
    FN_BAD   = 2'd3
  } dma_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } dma_st_e;

  // Linear address of (row, col) in a strided 2D layout.
  function automatic logic [31:0] lin_addr(input logic [31:0] base,
                                           input logic [31:0] gap,
                                           input logic [31:0] len,
                                           input logic [31:0] row,
                                           input logic [31:0] col);
    return base + row * (len + gap) + col;
  endfunction

  function automatic logic fn_valid(input logic [1:0] f);
    return f != FN_BAD;
  endfunction

endpackage

// File: rtl/dma2d_ctx.sv
module dma2d_ctx #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [1:0]        fn_i,
  input  logic [AW-1:0]     sa_i,
  input  logic [AW-1:0]     sa2_i,
  input  logic [AW-1:0]     sg_i,
  input  logic [AW-1:0]     da_i,
  input  logic [AW-1:0]     dg_i,
  input  logic [CW-1:0]     rows_i,
  input  logic [CW-1:0]     cols_i,
  input  logic [CW-1:0]     cols2_i,
  output dma2d_pkg::dma_fn_e fn_o,
  output logic [AW-1:0]     sa_o,
  output logic [AW-1:0]     sa2_o,
  output logic [AW-1:0]     sg_o,
  output logic [AW-1:0]     da_o,
  output logic [AW-1:0]     dg_o,
  output logic [CW-1:0]     rows_o,
  output logic [CW-1:0]     cols_o,
  output logic [CW-1:0]     cols2_o
);
  import dma2d_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_o    <= FN_COPY;
      sa_o    <= '0;
      sa2_o   <= '0;
      sg_o    <= '0;
      da_o    <= '0;
      dg_o    <= '0;
      rows_o  <= '0;
      cols_o  <= '0;
      cols2_o <= '0;
    end else if (load_i) begin
      fn_o    <= dma_fn_e'(fn_i);
      sa_o    <= sa_i;
      sa2_o   <= sa2_i;
      sg_o    <= sg_i;
      da_o    <= da_i;
      dg_o    <= dg_i;
      rows_o  <= rows_i;
      cols_o  <= cols_i;
      cols2_o <= cols2_i;
    end
  end

endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] rows_i,
  input  logic [CW-1:0] ncols_i,
  output logic [CW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          pass_o,
  output logic          end_of_pass_o
);
  logic col_last;
  logic row_last;

  assign col_last      = (col_o == ncols_i - CW'(1));
  assign row_last      = (row_o == rows_i - CW'(1));
  assign end_of_pass_o = col_last && row_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o  <= '0;
      col_o  <= '0;
      pass_o <= 1'b0;
    end else if (clr_i) begin
      row_o  <= '0;
      col_o  <= '0;
      pass_o <= 1'b0;
    end else if (step_i) begin
      if (col_last) begin
        col_o <= '0;
        if (row_last) begin
          row_o  <= '0;
          pass_o <= 1'b1;
        end else begin
          row_o <= row_o + CW'(1);
        end
      end else begin
        col_o <= col_o + CW'(1);
      end
    end
  end

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  dma2d_pkg::dma_fn_e fn_i,
  input  logic [AW-1:0]      sa_i,
  input  logic [AW-1:0]      sa2_i,
  input  logic [AW-1:0]      sg_i,
  input  logic [AW-1:0]      da_i,
  input  logic [AW-1:0]      dg_i,
  input  logic [CW-1:0]      rows_i,
  input  logic [CW-1:0]      cols_i,
  input  logic [CW-1:0]      cols2_i,
  input  logic [CW-1:0]      row_i,
  input  logic [CW-1:0]      col_i,
  input  logic               pass_i,
  output logic [AW-1:0]      src_addr_o,
  output logic [AW-1:0]      dst_addr_o
);
  import dma2d_pkg::*;

  logic [31:0] s_base, s_len, d_row, d_col, d_len;

  always_comb begin
    s_base = pass_i ? 32'(sa2_i) : 32'(sa_i);
    s_len  = pass_i ? 32'(cols2_i) : 32'(cols_i);
    unique case (fn_i)
      FN_XPOSE: begin
        d_row = 32'(col_i);
        d_col = 32'(row_i);
        d_len = 32'(rows_i);
      end
      FN_FUSE: begin
        d_row = 32'(row_i);
        d_col = 32'(col_i) + (pass_i ? 32'(cols_i) : 32'd0);
        d_len = 32'(cols_i) + 32'(cols2_i);
      end
      default: begin
        d_row = 32'(row_i);
        d_col = 32'(col_i);
        d_len = 32'(cols_i);
      end
    endcase
    src_addr_o = AW'(lin_addr(s_base, 32'(sg_i), s_len, 32'(row_i), 32'(col_i)));
    dst_addr_o = AW'(lin_addr(32'(da_i), 32'(dg_i), d_len, d_row, d_col));
  end

endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    func_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] src2_addr_i,
  input  logic [AW-1:0] src_gap_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [AW-1:0] dst_gap_i,
  input  logic [CW-1:0] rows_i,
  input  logic [CW-1:0] cols_i,
  input  logic [CW-1:0] cols2_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i
);
  import dma2d_pkg::*;

  dma_st_e     st;
  dma_fn_e     c_fn;
  logic [AW-1:0] c_sa, c_sa2, c_sg, c_da, c_dg;
  logic [CW-1:0] c_rows, c_cols, c_cols2;
  logic [CW-1:0] w_row, w_col;
  logic          w_pass, w_eop;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] data_q;

  // named internal events
  logic sess_go, sess_zero, rd_fire, wr_fire, more_pass;

  assign sess_go   = start_i && (st == ST_IDLE) && fn_valid(func_i);
  assign sess_zero = (rows_i == '0) || (cols_i == '0);
  assign rd_fire   = (st == ST_RD) && mem_rdy_i;
  assign wr_fire   = (st == ST_WR) && mem_rdy_i;
  assign more_pass = (c_fn == FN_FUSE) && !w_pass && (c_cols2 != '0);

  dma2d_ctx #(.AW(AW), .CW(CW)) ctx_i (
    .clk(clk), .rst_n(rst_n), .load_i(sess_go), .fn_i(func_i),
    .sa_i(src_addr_i), .sa2_i(src2_addr_i), .sg_i(src_gap_i),
    .da_i(dst_addr_i), .dg_i(dst_gap_i),
    .rows_i(rows_i), .cols_i(cols_i), .cols2_i(cols2_i),
    .fn_o(c_fn), .sa_o(c_sa), .sa2_o(c_sa2), .sg_o(c_sg),
    .da_o(c_da), .dg_o(c_dg),
    .rows_o(c_rows), .cols_o(c_cols), .cols2_o(c_cols2)
  );

  dma2d_walker #(.CW(CW)) walk_i (
    .clk(clk), .rst_n(rst_n), .clr_i(sess_go), .step_i(wr_fire),
    .rows_i(c_rows), .ncols_i(w_pass ? c_cols2 : c_cols),
    .row_o(w_row), .col_o(w_col), .pass_o(w_pass), .end_of_pass_o(w_eop)
  );

  dma2d_addr #(.AW(AW), .CW(CW)) addr_i (
    .fn_i(c_fn), .sa_i(c_sa), .sa2_i(c_sa2), .sg_i(c_sg),
    .da_i(c_da), .dg_i(c_dg),
    .rows_i(c_rows), .cols_i(c_cols), .cols2_i(c_cols2),
    .row_i(w_row), .col_i(w_col), .pass_i(w_pass),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      data_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (sess_go) st <= sess_zero ? ST_FIN : ST_RD;
        ST_RD: if (rd_fire) begin
          data_q <= mem_rdata_i;
          st     <= ST_WR;
        end
        ST_WR: if (wr_fire) st <= (w_eop && !more_pass) ? ST_FIN : ST_RD;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != ST_IDLE);
  assign done_o      = (st == ST_FIN);
  assign mem_req_o   = (st == ST_RD) || (st == ST_WR);
  assign mem_we_o    = (st == ST_WR);
  assign mem_addr_o  = (st == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata_o = data_q;

endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    func_i,
  input logic [CW-1:0] rows_i,
  input logic [CW-1:0] cols_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          mem_rdy_i
);
  logic [DW-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else if (mem_req_o && !mem_we_o && mem_rdy_i) cap <= mem_rdata_i;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o && mem_rdy_i) |=> (mem_req_o && mem_we_o));

  p_wr_then_not_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_rdy_i) |=> !(mem_req_o && mem_we_o));

  p_wdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o == cap));

  p_bad_fn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && func_i == 2'd3) |=> !busy_o);

  p_zero_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && func_i != 2'd3 && (rows_i == '0 || cols_i == '0))
      |=> (done_o && !mem_req_o));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !done_o));

endmodule

bind dma2d_engine dma2d_checker #(.AW(AW), .CW(CW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
  .rows_i(rows_i), .cols_i(cols_i), .busy_o(busy_o), .done_o(done_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
);

// File: tb/dma2d_engine_tb_top.sv
module dma2d_engine_tb_top;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int SB = 16, S2B = 200, DB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start;
  logic [1:0]    func;
  logic [AW-1:0] sa, sa2, sg, da, dg;
  logic [CW-1:0] rows, cols, cols2;
  logic          busy, done, req, we, rdy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  logic [7:0] mem [1024];
  int tests = 0, fails = 0;
  int cyc = 0, rd_n = 0, wr_n = 0, done_n = 0, lastw = 0, donecyc = 0, stall_viol = 0;
  logic stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;

  dma2d_engine #(.AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .func_i(func),
    .src_addr_i(sa), .src2_addr_i(sa2), .src_gap_i(sg),
    .dst_addr_i(da), .dst_gap_i(dg),
    .rows_i(rows), .cols_i(cols), .cols2_i(cols2),
    .busy_o(busy), .done_o(done), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rdy_i(rdy)
  );

  assign rdata = mem[addr[9:0]];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy  <= stall_mode ? lfsr[0] : 1'b1;
  end

  // memory model and monitor
  always @(posedge clk) begin
    if (req && rdy) begin
      if (we) begin
        mem[addr[9:0]] = wdata;
        wr_n++;
        lastw = cyc;
      end else rd_n++;
    end
    if (done) begin
      done_n++;
      donecyc = cyc;
    end
    if (rst_n && p_req && !p_rdy && (!req || addr != p_addr || we != p_we)) stall_viol++;
    p_req = req; p_rdy = rdy; p_we = we; p_addr = addr;
    cyc++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] fn;
    logic [7:0] r;
    logic [7:0] c;
    logic [7:0] l;
    logic [7:0] sgap;
    logic [7:0] dgap;
    logic       stall;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{2'd0, 8'd3, 8'd4, 8'd0, 8'd1, 8'd2, 1'b0},
    '{2'd0, 8'd1, 8'd6, 8'd0, 8'd0, 8'd0, 1'b1},
    '{2'd1, 8'd3, 8'd5, 8'd0, 8'd2, 8'd1, 1'b0},
    '{2'd1, 8'd4, 8'd4, 8'd0, 8'd0, 8'd3, 1'b1},
    '{2'd2, 8'd3, 8'd2, 8'd3, 8'd1, 8'd1, 1'b0},
    '{2'd2, 8'd2, 8'd3, 8'd0, 8'd2, 8'd0, 1'b1},
    '{2'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd2, 1'b1}
  };

  task automatic fill_mem();
    for (int a = 0; a < 1024; a++) mem[a] = pat(a);
  endtask

  task automatic run_vec(input vec_t v);
    int rd0, wr0, dn0, nel, drows, dw, bad, wrd, s, d, to;
    fill_mem();
    stall_mode = v.stall;
    rd0 = rd_n; wr0 = wr_n; dn0 = done_n;
    @(negedge clk);
    func = v.fn; sa = AW'(SB); sa2 = AW'(S2B); sg = AW'(v.sgap);
    da = AW'(DB); dg = AW'(v.dgap); rows = v.r; cols = v.c; cols2 = v.l;
    start = 1'b1;
    @(negedge clk);
    // R9: scramble context; R10: second start while busy
    func = 2'd0; sa = 16'd300; sa2 = 16'd320; sg = 16'd5; da = 16'd700;
    dg = 16'd9; rows = 8'd2; cols = 8'd2; cols2 = 8'd2;
    @(negedge clk);
    start = 1'b0;
    to = 0;
    while (!done && to < 3000) begin
      @(negedge clk);
      to++;
    end
    chk(to < 3000, "R11 done reached", to, 0);
    wrd = wr_n;
    repeat (4) @(negedge clk);
    chk(!busy && wr_n == wrd && done_n == dn0 + 1, "R10 no second session", done_n - dn0, 1);
    chk(donecyc == lastw + 1, "R11 done one cycle after last write", donecyc - lastw, 1);
    nel = v.r * v.c + ((v.fn == 2'd2) ? v.r * v.l : 0);
    chk(wr_n - wr0 == nel, "R5 write count", wr_n - wr0, nel);
    chk(rd_n - rd0 == nel, "R5 read count", rd_n - rd0, nel);
    drows = (v.fn == 2'd1) ? v.c : v.r;
    dw    = (v.fn == 2'd1) ? v.r : ((v.fn == 2'd2) ? v.c + v.l : v.c);
    bad = 0;
    for (int i = 0; i < drows; i++) begin
      for (int j = 0; j < dw + v.dgap; j++) begin
        d = DB + i * (dw + v.dgap) + j;
        if (j >= dw) s = d;
        else if (v.fn == 2'd1) s = SB + j * (v.c + v.sgap) + i;
        else if (v.fn == 2'd2 && j >= v.c) s = S2B + i * (v.l + v.sgap) + (j - v.c);
        else s = SB + i * (v.c + v.sgap) + j;
        if (mem[d] != pat(s)) bad++;
      end
    end
    chk(bad == 0, "R1/R2/R3 R4 R9 destination contents", bad, 0);
  endtask

  task automatic run_zero(input logic [1:0] f, input logic [7:0] r, input logic [7:0] c);
    int acc0;
    acc0 = rd_n + wr_n;
    @(negedge clk);
    func = f; rows = r; cols = c; cols2 = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !req, "R8 done in cycle after start", int'(done), 1);
    @(negedge clk);
    chk(!busy && !done && (rd_n + wr_n == acc0), "R8 no access", rd_n + wr_n - acc0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int dn0, acc0;
    start = 1'b0; func = '0; sa = '0; sa2 = '0; sg = '0; da = '0; dg = '0;
    rows = '0; cols = '0; cols2 = '0;
    fill_mem();
    repeat (3) @(negedge clk);
    chk(!busy && !req && !done, "R12 reset state", int'(busy) + int'(req) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req && !done, "R12 idle after reset", int'(busy) + int'(req) + int'(done), 0);

    for (int k = 0; k < 7; k++) run_vec(VT[k]);
    chk(stall_viol == 0, "R6 request held while stalled", stall_viol, 0);

    // R7: invalid function code
    dn0 = done_n; acc0 = rd_n + wr_n;
    @(negedge clk);
    func = 2'd3; rows = 8'd2; cols = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R7 invalid function stays idle", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(done_n == dn0 && rd_n + wr_n == acc0, "R7 no done no access",
        done_n - dn0 + rd_n + wr_n - acc0, 0);

    run_zero(2'd0, 8'd0, 8'd3);
    run_zero(2'd2, 8'd2, 8'd0);
    run_zero(2'd1, 8'd0, 8'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule